// File: doc/BRIEF.md
# Ring Replica Recovery Sequencer

After one node of a four-node ring fails, two configuration images lose their reachable copies. Every node keeps its own image and a backup of the image of the next node around the ring. When node k dies, image k survives only at node k-1, and image k+1 survives only at its owner, node k+1. This block takes the index of the failed node and a choice of recovery plan. From these it produces an ordered stream of memory-to-memory copy commands that re-create two reachable copies of both images. Moving the data itself is the job of other logic, which reports the end of each copy with a done pulse on the link that carried it.

Two plans exist. The ring-only plan uses only the secondary ring link. Each image moves in two hops and is parked in the reserved transit segment of node k+2 between the hops. The dual-network plan issues one ring copy and one copy over the primary switched network back to back, then waits for both to finish. A dual-network request made while the primary network is marked unhealthy runs the ring-only plan instead. Commands leave on a valid/ready channel. A command stays on the channel unchanged until it is accepted. In ring-only mode the next command waits for the ring done pulse of the current one.

Top module: `ring_replica_recovery`

## Requirements
- R1: After reset, `cmd_valid`, `busy`, `complete` and `err` are all low.
- R2: A ring-only recovery of fault node k issues exactly four commands, all with `cmd_link`=0, in this order (node arithmetic is modulo 4; fields are src, dst, img): (k+1, k+2, k+1), (k+2, k-1, k+1), (k-1, k+2, k), (k+2, k+1, k).
- R3: A dual-network recovery (`req_dual`=1 with `primary_ok`=1) issues (k+1, k+2, k+1) with `cmd_link`=0 and then (k-1, k+1, k) with `cmd_link`=1. The second command is offered right after the first is accepted, with no done pulse needed in between.
- R4: If `primary_ok` is low in the request cycle, a `req_dual`=1 request runs the R2 sequence.
- R5: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and `cmd_src`, `cmd_dst`, `cmd_img` and `cmd_link` hold their values.
- R6: In ring-only mode, after a command is accepted, `cmd_valid` stays low until a `done_ring` pulse arrives. A `done_prim` pulse has no effect in this mode.
- R7: In dual-network mode the recovery ends only after both `done_ring` and `done_prim` have been seen. The two pulses may come in either order or in the same cycle.
- R8: A request with `req_node` of 4 or more (MSB set) makes `err` high for exactly one cycle, one cycle later, and starts no recovery.
- R9: A request made while `busy` is high makes `err` high for one cycle. It does not change the running sequence.
- R10: `busy` rises in the cycle after an accepted request. It falls in the cycle after the last done pulse, and in that same cycle `complete` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle recovery request strobe |
| req_node | input | NODE_W+1 | Index of the failed node; MSB set means out of range |
| req_dual | input | 1 | 1 selects the dual-network plan, 0 the ring-only plan |
| primary_ok | input | 1 | Primary switched network healthy, sampled with the request |
| cmd_valid | output | 1 | Copy command offered |
| cmd_ready | input | 1 | Copy command accepted when high together with `cmd_valid` |
| cmd_src | output | NODE_W | Node the image is read from |
| cmd_dst | output | NODE_W | Node the image is written to |
| cmd_img | output | NODE_W | Image identifier (owner node index) |
| cmd_link | output | 1 | 0 = secondary ring link, 1 = primary network |
| done_ring | input | 1 | One-cycle pulse: a ring-link copy finished |
| done_prim | input | 1 | One-cycle pulse: a primary-network copy finished |
| busy | output | 1 | Recovery in progress |
| complete | output | 1 | One-cycle pulse when a recovery ends |
| err | output | 1 | One-cycle pulse when a request is refused |

## Verification
Two events can land in the same cycle. The first is the pair of completion pulses of a dual-network recovery. The bench raises `done_ring` and `done_prim` in one cycle and expects `complete` exactly one cycle later, with `busy` falling at the same moment. The second is a request that arrives while a sequence is running. Here the bench expects `err` to pulse and checks that the running sequence then issues its remaining commands unchanged.

// File: rtl/rrr_pkg.sv
package rrr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } rrr_state_e;

  localparam int STEP_W     = 2;
  localparam int RING_STEPS = 4;
  localparam int DUAL_STEPS = 2;

  localparam logic LINK_RING    = 1'b0;
  localparam logic LINK_PRIMARY = 1'b1;
endpackage

// File: rtl/rrr_planner.sv
module rrr_planner
  import rrr_pkg::*;
#(
  parameter int NODE_W = 2
) (
  input  logic [NODE_W-1:0] fault_k,
  input  logic              dual_mode,
  input  logic [STEP_W-1:0] step,
  output logic [NODE_W-1:0] src,
  output logic [NODE_W-1:0] dst,
  output logic [NODE_W-1:0] img,
  output logic              link
);
  logic [NODE_W-1:0] k_next, k_next2, k_prev;

  // neighbour arithmetic wraps naturally at the ring size
  assign k_next  = fault_k + NODE_W'(1);
  assign k_next2 = fault_k + NODE_W'(2);
  assign k_prev  = fault_k - NODE_W'(1);

  always_comb begin
    src  = k_next;
    dst  = k_next2;
    img  = k_next;
    link = LINK_RING;
    if (dual_mode) begin
      if (step != '0) begin
        src  = k_prev;
        dst  = k_next;
        img  = fault_k;
        link = LINK_PRIMARY;
      end
    end else begin
      case (step)
        2'd0: begin src = k_next;  dst = k_next2; img = k_next;  end
        2'd1: begin src = k_next2; dst = k_prev;  img = k_next;  end
        2'd2: begin src = k_prev;  dst = k_next2; img = fault_k; end
        default: begin src = k_next2; dst = k_next; img = fault_k; end
      endcase
    end
  end
endmodule

// File: rtl/rrr_ctrl.sv
module rrr_ctrl
  import rrr_pkg::*;
#(
  parameter int NODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [NODE_W:0]   req_node,
  input  logic              req_dual,
  input  logic              primary_ok,
  input  logic              cmd_ready,
  input  logic              done_ring,
  input  logic              done_prim,
  output logic              issue,
  output logic [NODE_W-1:0] fault_k,
  output logic              dual_mode,
  output logic [STEP_W-1:0] step,
  output logic              busy,
  output logic              complete,
  output logic              err
);
  localparam logic [STEP_W-1:0] RING_LAST = STEP_W'(RING_STEPS - 1);
  localparam logic [STEP_W-1:0] DUAL_LAST = STEP_W'(DUAL_STEPS - 1);

  rrr_state_e state;
  logic       seen_ring, seen_prim;
  logic       node_ok;
  logic       dual_all;

  assign node_ok  = ~req_node[NODE_W];
  assign issue    = (state == ST_ISSUE);
  assign busy     = (state != ST_IDLE);
  assign dual_all = (seen_ring | done_ring) & (seen_prim | done_prim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      fault_k   <= '0;
      dual_mode <= 1'b0;
      step      <= '0;
      seen_ring <= 1'b0;
      seen_prim <= 1'b0;
      complete  <= 1'b0;
      err       <= 1'b0;
    end else begin
      complete <= 1'b0;
      err      <= req_valid & (busy | ~node_ok);
      if (dual_mode && busy) begin
        seen_ring <= seen_ring | done_ring;
        seen_prim <= seen_prim | done_prim;
      end
      case (state)
        ST_IDLE: begin
          if (req_valid && node_ok) begin
            fault_k   <= req_node[NODE_W-1:0];
            dual_mode <= req_dual & primary_ok;
            step      <= '0;
            seen_ring <= 1'b0;
            seen_prim <= 1'b0;
            state     <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (cmd_ready) begin
            if (dual_mode && step != DUAL_LAST) step  <= step + STEP_W'(1);
            else                                state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (dual_mode) begin
            if (dual_all) begin
              state    <= ST_IDLE;
              complete <= 1'b1;
            end
          end else if (done_ring) begin
            if (step == RING_LAST) begin
              state    <= ST_IDLE;
              complete <= 1'b1;
            end else begin
              step  <= step + STEP_W'(1);
              state <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_replica_recovery.sv
module ring_replica_recovery
  import rrr_pkg::*;
#(
  parameter int NODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [NODE_W:0]   req_node,
  input  logic              req_dual,
  input  logic              primary_ok,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [NODE_W-1:0] cmd_src,
  output logic [NODE_W-1:0] cmd_dst,
  output logic [NODE_W-1:0] cmd_img,
  output logic              cmd_link,
  input  logic              done_ring,
  input  logic              done_prim,
  output logic              busy,
  output logic              complete,
  output logic              err
);
  logic [NODE_W-1:0] fault_k;
  logic              dual_mode;
  logic [STEP_W-1:0] step;

  rrr_ctrl #(.NODE_W(NODE_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_node   (req_node),
    .req_dual   (req_dual),
    .primary_ok (primary_ok),
    .cmd_ready  (cmd_ready),
    .done_ring  (done_ring),
    .done_prim  (done_prim),
    .issue      (cmd_valid),
    .fault_k    (fault_k),
    .dual_mode  (dual_mode),
    .step       (step),
    .busy       (busy),
    .complete   (complete),
    .err        (err)
  );

  rrr_planner #(.NODE_W(NODE_W)) u_plan (
    .fault_k   (fault_k),
    .dual_mode (dual_mode),
    .step      (step),
    .src       (cmd_src),
    .dst       (cmd_dst),
    .img       (cmd_img),
    .link      (cmd_link)
  );
endmodule

// File: rtl/rrr_checker.sv
module rrr_checker #(
  parameter int NODE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [NODE_W:0]   req_node,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [NODE_W-1:0] cmd_src,
  input logic [NODE_W-1:0] cmd_dst,
  input logic [NODE_W-1:0] cmd_img,
  input logic              cmd_link,
  input logic              done_ring,
  input logic              done_prim,
  input logic              busy,
  input logic              complete,
  input logic              err
);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_src) && $stable(cmd_dst)
                                && $stable(cmd_img) && $stable(cmd_link));

  assert_bad_node_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_node[NODE_W] && !busy |=> err && !busy && !cmd_valid);

  assert_busy_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && busy && !done_ring && !done_prim |=> err && busy);

  assert_complete_R10: assert property (@(posedge clk) disable iff (!rst_n)
    complete |-> !busy && $past(busy));

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> !complete);

  assert_cmd_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);
endmodule

bind ring_replica_recovery rrr_checker #(.NODE_W(NODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_node  (req_node),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_src   (cmd_src),
  .cmd_dst   (cmd_dst),
  .cmd_img   (cmd_img),
  .cmd_link  (cmd_link),
  .done_ring (done_ring),
  .done_prim (done_prim),
  .busy      (busy),
  .complete  (complete),
  .err       (err)
);

// File: tb/ring_replica_recovery_tb.sv
module ring_replica_recovery_tb;
  localparam int NODE_W = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [NODE_W:0]   req_node = '0;
  logic              req_dual = 1'b0;
  logic              primary_ok = 1'b1;
  logic              cmd_valid;
  logic              cmd_ready = 1'b0;
  logic [NODE_W-1:0] cmd_src, cmd_dst, cmd_img;
  logic              cmd_link;
  logic              done_ring = 1'b0;
  logic              done_prim = 1'b0;
  logic              busy, complete, err;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  ring_replica_recovery #(.NODE_W(NODE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_node(req_node),
    .req_dual(req_dual), .primary_ok(primary_ok), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_src(cmd_src), .cmd_dst(cmd_dst),
    .cmd_img(cmd_img), .cmd_link(cmd_link), .done_ring(done_ring),
    .done_prim(done_prim), .busy(busy), .complete(complete), .err(err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic request(input int node, input bit dual, input bit pok);
    req_valid  = 1'b1;
    req_node   = (NODE_W+1)'(node);
    req_dual   = dual;
    primary_ok = pok;
    @(negedge clk);
    req_valid  = 1'b0;
  endtask

  // waits for an offered command, applies `hold` cycles of back-pressure, accepts it
  task automatic take_cmd(input string req, input int s, input int d, input int i,
                          input int l, input int hold);
    int n = 0;
    while (!cmd_valid && n < 20) begin @(negedge clk); n++; end
    check({req, " cmd_valid"}, int'(cmd_valid), 1);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check("R5 valid held", int'(cmd_valid), 1);
      check("R5 src held", int'(cmd_src), s);
    end
    check({req, " src"}, int'(cmd_src), s);
    check({req, " dst"}, int'(cmd_dst), d);
    check({req, " img"}, int'(cmd_img), i);
    check({req, " link"}, int'(cmd_link), l);
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
  endtask

  task automatic pulse_done(input bit r, input bit p);
    done_ring = r;
    done_prim = p;
    @(negedge clk);
    done_ring = 1'b0;
    done_prim = 1'b0;
  endtask

  task automatic expect_end(input string req);
    check({req, " complete"}, int'(complete), 1);
    check({req, " busy low"}, int'(busy), 0);
    @(negedge clk);
    check({req, " complete one cycle"}, int'(complete), 0);
  endtask

  // R2 sequence for fault k; when probe_busy, a stray request is issued mid-run (R9)
  task automatic run_ring(input string req, input int k, input bit dual, input int hold,
                          input bit probe_busy);
    int k1 = (k + 1) % 4, k2 = (k + 2) % 4, km = (k + 3) % 4;
    request(k, dual, 1'b0);
    check("R10 busy after request", int'(busy), 1);
    for (int st = 0; st < 4; st++) begin
      int s, d, i;
      case (st)
        0: begin s = k1; d = k2; i = k1; end
        1: begin s = k2; d = km; i = k1; end
        2: begin s = km; d = k2; i = k;  end
        default: begin s = k2; d = k1; i = k; end
      endcase
      take_cmd(req, s, d, i, 0, (st == 1) ? hold : 0);
      check("R6 no command before done", int'(cmd_valid), 0);
      if (st == 0) begin
        pulse_done(1'b0, 1'b1);
        check("R6 done_prim ignored", int'(cmd_valid), 0);
        check("R6 still busy", int'(busy), 1);
        if (probe_busy) begin
          request(1, 1'b0, 1'b1);
          check("R9 err while busy", int'(err), 1);
          check("R9 busy kept", int'(busy), 1);
          check("R9 no new command", int'(cmd_valid), 0);
        end
      end
      pulse_done(1'b1, 1'b0);
    end
    expect_end(req);
  endtask

  task automatic run_dual(input int k, input bit same_cycle);
    int k1 = (k + 1) % 4, k2 = (k + 2) % 4, km = (k + 3) % 4;
    request(k, 1'b1, 1'b1);
    take_cmd("R3 first", k1, k2, k1, 0, 0);
    check("R3 second offered at once", int'(cmd_valid), 1);
    take_cmd("R3 second", km, k1, k, 1, 0);
    if (same_cycle) begin
      pulse_done(1'b1, 1'b1);
    end else begin
      pulse_done(1'b0, 1'b1);
      check("R7 waits for ring done", int'(busy), 1);
      check("R7 no complete yet", int'(complete), 0);
      pulse_done(1'b1, 1'b0);
    end
    expect_end("R7");
  endtask

  task automatic bad_node();
    request(5, 1'b0, 1'b1);
    check("R8 err", int'(err), 1);
    check("R8 not busy", int'(busy), 0);
    check("R8 no command", int'(cmd_valid), 0);
    @(negedge clk);
    check("R8 err one cycle", int'(err), 0);
    check("R8 still idle", int'(busy), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 cmd_valid", int'(cmd_valid), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 complete", int'(complete), 0);
    check("R1 err", int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_ring("R2 k1", 1, 1'b0, 3, 1'b0);
    run_ring("R2 k3 wrap", 3, 1'b0, 0, 1'b0);
    run_dual(0, 1'b0);
    run_dual(2, 1'b1);
    run_ring("R4 fallback k2", 2, 1'b1, 0, 1'b0);
    bad_node();
    run_ring("R9 k0", 0, 1'b0, 2, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule